// File: doc/BRIEF.md
# Handshaked Indirect PHY Register Port

This block lets software reach a bank of 16-bit PHY registers that are not mapped into the address space. Software sees two 32-bit words: a control word that it writes and a status word that it reads. The control word carries a 16-bit field and four strobe bits. Raising a strobe starts one step of an access. The block answers the step by raising an acknowledge bit in the status word. Once software clears the strobe, the block lowers the acknowledge again.

Every access is made of steps. A read first captures the target index through the capture-address strobe, then raises the read strobe. The register value appears in the status word by the time the acknowledge rises. A write captures the index, then captures the data word, then raises the write strobe, which commits the captured data to the captured index. Each step is a full raise/acknowledge/clear/release cycle. The acknowledge follows each strobe edge after a parameterised latency of one to four clocks, which lets software polling loops be exercised. A small register array inside the block stands in for the PHY. Each register has a computed reset default.

Top module: `phy_indirect_port`

## Requirements
- R1: After reset the status word reads zero: the acknowledge is low, the read-data field is 0 and the captured index and data are 0.
- R2: In the control word, the field is bits 15:0, capture-address is bit 16, capture-data is bit 17, write is bit 18 and read is bit 19. In the status word, read data is bits 15:0, the acknowledge is bit 16, and bits 31:17 always read 0.
- R3: A capture-address strobe latches the field as the target index. The acknowledge rises ACK_LAT clock edges after the edge that loads the strobe into the control word. It falls ACK_LAT edges after the edge that loads a control word with that strobe cleared.
- R4: A capture-data strobe latches the field as the pending write data, with its own acknowledge rise and fall.
- R5: A write strobe stores the pending data into the register at the captured index, with its own acknowledge rise and fall.
- R6: A read strobe copies the register at the captured index into status bits 15:0 no later than the acknowledge rise. The value is held there until the next read is served.
- R7: A strobe raised while another strobe owns the handshake is ignored until the acknowledge has fallen. If it is still high at that point, it is then served.
- R8: When several strobes are high while the port is idle, one is served at a time in this order: capture-address first, then capture-data, then write, then read.
- R9: An index outside BASE_ADDR .. BASE_ADDR+NUM_REGS-1 is handled as follows: a write to it is dropped and changes no register, and a read of it returns 0xFFFF.
- R10: After reset, the register at index BASE_ADDR+i holds DEF_BASE + i*DEF_STEP, truncated to 16 bits. With the defaults this is 0xC000 + i*0x0111, so 0x1005 holds 0xC555 and 0x100D holds 0xCDDD.
- R11: ACK_LAT is limited to 1..4, and the same latency applies to both edges of every step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Loads ctrl_wdata into the control word at the next rising edge |
| ctrl_wdata | input | 32 | New control word: field and strobe bits |
| stat_rdata | output | 32 | Status word: read data and acknowledge |

## Verification
The hardest situation to reach is a second strobe that arrives while the first still holds the acknowledge. At that moment the second strobe must leave no trace until the first has been fully released. The bench creates it by rewriting the control word during a held capture-data step so that the read strobe is also set. It then checks that the acknowledge stays high and the read field keeps its old value. After that it clears only the capture-data bit and watches the acknowledge fall and rise again as the deferred read is served. The priority case works the same way: capture-address and read are set together in a single write, and the bench watches the two steps complete in order.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
   localparam int FIELD_W     = 16;
   localparam int WORD_W      = 32;
   localparam int NUM_STROBES = 4;

   // strobe positions inside the strobe group (control bits 16 + index)
   localparam int SB_CAPA = 0;
   localparam int SB_CAPD = 1;
   localparam int SB_WR   = 2;
   localparam int SB_RD   = 3;

   localparam int STROBE_LSB = 16;
   localparam int ACK_BIT    = 16;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RISE,
      ST_HOLD,
      ST_FALL
   } hs_state_t;
endpackage

// File: rtl/phy_port_arb.sv
module phy_port_arb
   import phy_port_pkg::*;
(
   input  logic [NUM_STROBES-1:0] req,
   output logic [NUM_STROBES-1:0] gnt
);
   // lowest index wins: capture-address, capture-data, write, read
   always_comb begin
      gnt = '0;
      for (int i = NUM_STROBES - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/phy_port_ctrl.sv
module phy_port_ctrl
   import phy_port_pkg::*;
#(
   parameter int ACK_LAT = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STROBES-1:0] strobe,
   input  logic [NUM_STROBES-1:0] gnt,
   output logic [NUM_STROBES-1:0] fire,
   output logic                   ack
);
   localparam int       CNT_W = 3;
   localparam logic [CNT_W-1:0] LOAD    = CNT_W'(ACK_LAT - 1);
   localparam logic [CNT_W-1:0] LAT_VAL = CNT_W'(ACK_LAT);

   generate
      if (ACK_LAT < 1 || ACK_LAT > 4) begin : g_bad_lat
         $error("phy_port_ctrl: ACK_LAT must lie in 1..4");
      end
   endgenerate

   hs_state_t              st;
   logic [CNT_W-1:0]       cnt;
   logic [NUM_STROBES-1:0] owner;
   logic                   start_ev;
   logic                   release_ev;

   assign start_ev   = (st == ST_IDLE) && (|gnt);
   assign release_ev = (st == ST_HOLD) && ((strobe & owner) == '0);

   always_comb begin
      fire = '0;
      if (st == ST_IDLE) fire = gnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         owner <= '0;
         ack   <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start_ev) begin
                  owner <= gnt;
                  if (LOAD == '0) begin
                     ack <= 1'b1;
                     st  <= ST_HOLD;
                  end else begin
                     cnt <= LOAD;
                     st  <= ST_RISE;
                  end
               end
            end
            ST_RISE: begin
               if (cnt == CNT_W'(1)) begin
                  ack <= 1'b1;
                  cnt <= '0;
                  st  <= ST_HOLD;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_HOLD: begin
               if (release_ev) begin
                  if (LOAD == '0) begin
                     ack   <= 1'b0;
                     owner <= '0;
                     st    <= ST_IDLE;
                  end else begin
                     cnt <= LOAD;
                     st  <= ST_FALL;
                  end
               end
            end
            default: begin
               if (cnt == CNT_W'(1)) begin
                  ack   <= 1'b0;
                  owner <= '0;
                  cnt   <= '0;
                  st    <= ST_IDLE;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
         endcase
      end
   end

   // independent latency counter used only by the checks below
   logic [CNT_W-1:0] chk_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       chk_cnt <= '0;
      else if (start_ev || release_ev)  chk_cnt <= CNT_W'(1);
      else if (chk_cnt != '1)           chk_cnt <= chk_cnt + CNT_W'(1);
   end

   AST_ACK_RISE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> chk_cnt == LAT_VAL);  // R3
   AST_ACK_FALL_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> chk_cnt == LAT_VAL);  // R11
   AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner));  // R8
   AST_ACK_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> owner != '0);  // R7
endmodule

// File: rtl/phy_port_bank.sv
module phy_port_bank
   import phy_port_pkg::*;
#(
   parameter int                  NUM_REGS  = 16,
   parameter logic [FIELD_W-1:0]  BASE_ADDR = 16'h1000,
   parameter logic [FIELD_W-1:0]  DEF_BASE  = 16'hC000,
   parameter logic [FIELD_W-1:0]  DEF_STEP  = 16'h0111,
   parameter logic [FIELD_W-1:0]  FILL      = 16'hFFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [FIELD_W-1:0] wr_addr,
   input  logic [FIELD_W-1:0] wr_data,
   input  logic [FIELD_W-1:0] rd_addr,
   output logic [FIELD_W-1:0] rd_data
);
   localparam logic [FIELD_W:0] LO_BOUND = {1'b0, BASE_ADDR};
   localparam logic [FIELD_W:0] HI_BOUND = (FIELD_W+1)'(BASE_ADDR) + (FIELD_W+1)'(NUM_REGS);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_depth
         $error("phy_port_bank: NUM_REGS must lie in 1..256");
      end
   endgenerate

   logic [NUM_REGS-1:0][FIELD_W-1:0] regs;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         localparam logic [FIELD_W-1:0] DEF_VAL = FIELD_W'(DEF_BASE + gi * DEF_STEP);
         localparam logic [FIELD_W-1:0] MY_ADDR = FIELD_W'(BASE_ADDR + gi);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         regs[gi] <= DEF_VAL;
            else if (we && wr_addr == MY_ADDR)  regs[gi] <= wr_data;
         end
      end
   endgenerate

   always_comb begin
      rd_data = FILL;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == FIELD_W'(BASE_ADDR + i)) rd_data = regs[i];
      end
   end

   logic wr_in_win;
   assign wr_in_win = ({1'b0, wr_addr} >= LO_BOUND) && ({1'b0, wr_addr} < HI_BOUND);

   AST_OUT_OF_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wr_in_win) |=> $stable(regs));  // R9
   AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs));  // R5
endmodule

// File: rtl/phy_indirect_port.sv
module phy_indirect_port
   import phy_port_pkg::*;
#(
   parameter int                  ACK_LAT   = 2,
   parameter int                  NUM_REGS  = 16,
   parameter logic [FIELD_W-1:0]  BASE_ADDR = 16'h1000,
   parameter logic [FIELD_W-1:0]  DEF_BASE  = 16'hC000,
   parameter logic [FIELD_W-1:0]  DEF_STEP  = 16'h0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [WORD_W-1:0] ctrl_wdata,
   output logic [WORD_W-1:0] stat_rdata
);
   logic [WORD_W-1:0]      ctrl_q;
   logic [NUM_STROBES-1:0] strobes;
   logic [NUM_STROBES-1:0] gnt;
   logic [NUM_STROBES-1:0] fire;
   logic                   ack;
   logic [FIELD_W-1:0]     field;
   logic [FIELD_W-1:0]     addr_q;
   logic [FIELD_W-1:0]     data_q;
   logic [FIELD_W-1:0]     rdata_q;
   logic [FIELD_W-1:0]     bank_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= ctrl_wdata;
   end

   assign field   = ctrl_q[FIELD_W-1:0];
   assign strobes = ctrl_q[STROBE_LSB +: NUM_STROBES];

   phy_port_arb u_arb (
      .req (strobes),
      .gnt (gnt)
   );

   phy_port_ctrl #(.ACK_LAT(ACK_LAT)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobes),
      .gnt    (gnt),
      .fire   (fire),
      .ack    (ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (fire[SB_CAPA]) addr_q  <= field;
         if (fire[SB_CAPD]) data_q  <= field;
         if (fire[SB_RD])   rdata_q <= bank_rd;
      end
   end

   phy_port_bank #(
      .NUM_REGS  (NUM_REGS),
      .BASE_ADDR (BASE_ADDR),
      .DEF_BASE  (DEF_BASE),
      .DEF_STEP  (DEF_STEP),
      .FILL      ('1)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (fire[SB_WR]),
      .wr_addr (addr_q),
      .wr_data (data_q),
      .rd_addr (addr_q),
      .rd_data (bank_rd)
   );

   always_comb begin
      stat_rdata                 = '0;
      stat_rdata[FIELD_W-1:0]    = rdata_q;
      stat_rdata[ACK_BIT]        = ack;
   end

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(ack)) |-> $stable(rdata_q));  // R6
   AST_ADDR_ONLY_ON_CAPA: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> $past(strobes[SB_CAPA]));  // R3
   AST_DATA_ONLY_ON_CAPD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_q) |-> $past(strobes[SB_CAPD]));  // R4
   AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rdata[WORD_W-1:ACK_BIT+1] == '0);  // R2
endmodule

// File: tb/tb_phy_indirect_port.sv
module tb_phy_indirect_port;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam logic [31:0] S_CAPA = 32'h0001_0000;
   localparam logic [31:0] S_CAPD = 32'h0002_0000;
   localparam logic [31:0] S_WR   = 32'h0004_0000;
   localparam logic [31:0] S_RD   = 32'h0008_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic [31:0] stat_rdata;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   phy_indirect_port #(.ACK_LAT(LAT)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .stat_rdata (stat_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] def_of(input int idx);
      return 16'(16'hC000 + idx * 16'h0111);
   endfunction

   task automatic wr_ctrl(input logic [31:0] v);
      @(negedge clk);
      ctrl_we    = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_we    = 1'b0;
   endtask

   task automatic wait_ack(input bit level, input string req);
      int n = 0;
      while (stat_rdata[16] !== level && n < 40) begin
         @(negedge clk);
         n++;
      end
      if (stat_rdata[16] !== level)
         check(1'b0, req, {31'b0, stat_rdata[16]}, {31'b0, level});
   endtask

   task automatic step(input logic [31:0] strobe, input logic [15:0] fld, input string req);
      wr_ctrl(strobe | {16'h0, fld});
      wait_ack(1'b1, req);
      wr_ctrl({16'h0, fld});
      wait_ack(1'b0, req);
   endtask

   task automatic phy_write(input logic [15:0] a, input logic [15:0] d);
      step(S_CAPA, a, "R3");
      step(S_CAPD, d, "R4");
      step(S_WR, d, "R5");
   endtask

   task automatic phy_read(input logic [15:0] a, output logic [15:0] d);
      step(S_CAPA, a, "R3");
      wr_ctrl(S_RD);
      wait_ack(1'b1, "R6");
      d = stat_rdata[15:0];
      wr_ctrl(32'h0);
      wait_ack(1'b0, "R6");
   endtask

   task automatic t_reset;
      check(stat_rdata == 32'h0, "R1 reset status", stat_rdata, 32'h0);
   endtask

   task automatic t_defaults;
      logic [15:0] d;
      phy_read(16'h1005, d);
      check(d == def_of(5), "R10 default 0x1005", {16'h0, d}, {16'h0, def_of(5)});
      phy_read(16'h100D, d);
      check(d == def_of(13), "R10 default 0x100D", {16'h0, d}, {16'h0, def_of(13)});
      phy_read(16'h1000, d);
      check(d == 16'hC000, "R6 read 0x1000", {16'h0, d}, 32'h0000_C000);
      check(stat_rdata[31:17] == '0, "R2 status upper bits", stat_rdata, {15'h0, stat_rdata[16:0]});
   endtask

   task automatic t_latency;
      wr_ctrl(S_CAPA | 32'h1001);
      check(stat_rdata[16] == 1'b0, "R3 ack before latency", {31'b0, stat_rdata[16]}, 32'h0);
      for (int k = 1; k <= LAT; k++) begin
         @(negedge clk);
         check(stat_rdata[16] == (k == LAT), "R11 ack rise timing",
               {31'b0, stat_rdata[16]}, {31'b0, (k == LAT)});
      end
      wr_ctrl(32'h1001);
      check(stat_rdata[16] == 1'b1, "R3 ack held after clear", {31'b0, stat_rdata[16]}, 32'h1);
      for (int k = 1; k <= LAT; k++) begin
         @(negedge clk);
         check(stat_rdata[16] == (k != LAT), "R11 ack fall timing",
               {31'b0, stat_rdata[16]}, {31'b0, (k != LAT)});
      end
   endtask

   task automatic t_write_read;
      logic [15:0] d;
      phy_write(16'h1005, 16'hBEEF);
      phy_read(16'h1005, d);
      check(d == 16'hBEEF, "R5 written value", {16'h0, d}, 32'h0000_BEEF);
      phy_read(16'h1004, d);
      check(d == def_of(4), "R5 neighbour untouched", {16'h0, d}, {16'h0, def_of(4)});
      check(stat_rdata[15:0] == def_of(4), "R6 read data held", stat_rdata, {16'h0, def_of(4)});
   endtask

   task automatic t_overlap;
      logic [15:0] d;
      phy_read(16'h1000, d);
      step(S_CAPA, 16'h1002, "R3");
      wr_ctrl(S_CAPD | 32'h7777);
      wait_ack(1'b1, "R4");
      wr_ctrl(S_CAPD | S_RD | 32'h7777);
      for (int k = 0; k < 2 * LAT + 2; k++) @(negedge clk);
      check(stat_rdata[16] == 1'b1, "R7 ack kept by owner", stat_rdata, 32'h0001_C000);
      check(stat_rdata[15:0] == 16'hC000, "R7 read ignored while acked", stat_rdata, 32'h0001_C000);
      wr_ctrl(S_RD | 32'h7777);
      wait_ack(1'b0, "R7");
      wait_ack(1'b1, "R7");
      check(stat_rdata[15:0] == def_of(2), "R7 deferred read served", stat_rdata, {16'h1, def_of(2)});
      wr_ctrl(32'h0);
      wait_ack(1'b0, "R7");
      step(S_WR, 16'h0, "R5");
      phy_read(16'h1002, d);
      check(d == 16'h7777, "R4 captured data committed", {16'h0, d}, 32'h0000_7777);
   endtask

   task automatic t_priority;
      wr_ctrl(S_CAPA | S_RD | 32'h1003);
      wait_ack(1'b1, "R8");
      check(stat_rdata[15:0] == 16'h7777, "R8 capture served before read", stat_rdata, 32'h0001_7777);
      wr_ctrl(S_RD | 32'h1003);
      wait_ack(1'b0, "R8");
      wait_ack(1'b1, "R8");
      check(stat_rdata[15:0] == def_of(3), "R8 read served second", stat_rdata, {16'h1, def_of(3)});
      wr_ctrl(32'h0);
      wait_ack(1'b0, "R8");
   endtask

   task automatic t_outside;
      logic [15:0] d;
      phy_write(16'h2000, 16'h1234);
      phy_read(16'h2000, d);
      check(d == 16'hFFFF, "R9 outside read", {16'h0, d}, 32'h0000_FFFF);
      phy_read(16'h1000, d);
      check(d == 16'hC000, "R9 inside untouched", {16'h0, d}, 32'h0000_C000);
      phy_read(16'h100F, d);
      check(d == def_of(15), "R9 last index in window", {16'h0, d}, {16'h0, def_of(15)});
      check(stat_rdata[31:17] == '0, "R2 status upper bits", stat_rdata, {15'h0, stat_rdata[16:0]});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_defaults();
      t_latency();
      t_write_read();
      t_overlap();
      t_priority();
      t_outside();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule